// File: doc/BRIEF.md
# Execute Redirect Squash Arbiter

This block sits at the exit of an out-of-order execute stage. Every cycle it receives a group of up to `LANES` finished instructions, already ordered oldest first in lane 0 upward. Each lane carries a thread number, a sequence number, the PC and the computed next PC. It also carries status bits for a branch mispredict (with the predicted direction), a memory-ordering violation and a blocked load (with a bit that says the blocked load was already dealt with).

For every hardware thread the block picks at most one redirect event from the group: the oldest lane of that thread with an event. It turns that event into a squash record for the commit stage. The record carries the sequence number to squash from, the mispredicted PC, the PC to restart at, a mispredict flag, a taken flag, and a flag that says whether the triggering instruction is squashed too. What the record holds depends on the cause. A winning blocked load is also reported back on a per-lane strobe so the load queue can mark it handled. Two running counters split the honoured mispredicts by predicted direction.

Top module: `exec_squash_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every `sqValid` bit, every `ldHandledSet` bit and both mispredict counters read zero.
- R2: A squash record for a thread appears on the outputs one clock after the lane group that caused it. `sqValid` for that thread is high for that one cycle only, unless the next group also produces an event for the same thread. A group with no event for a thread gives no record for it.
- R3: Within one group, only the lowest-numbered (oldest) lane with an event for a given thread is honoured. Events in higher lanes of the same thread are ignored. This selection starts afresh with every group, so back-to-back groups each produce their own record.
- R4: Threads are arbitrated independently. Several threads can each receive a record in the same cycle.
- R5: Within a single lane the cause priority is: branch mispredict first, memory-order violation second, blocked load whose handled bit is clear third.
- R6: A mispredict record holds the lane's sequence number, `sqMispredPc` = lane PC, `sqNextPc` = lane next PC, `sqMispredict` = 1 and `sqIncludeSelf` = 0.
- R7: On a mispredict record, `sqTaken` is 1 exactly when the next PC differs from PC + `INST_BYTES` (default 4). `sqTaken` is 0 for the other two causes.
- R8: A memory-order record holds the lane's sequence number, `sqNextPc` = lane next PC, `sqMispredPc` = 0, `sqMispredict` = 0 and `sqIncludeSelf` = 0.
- R9: A blocked-load record holds the lane's sequence number, `sqNextPc` = the lane's own PC, `sqIncludeSelf` = 1, `sqMispredict` = 0 and `sqMispredPc` = 0. In the same cycle, `ldHandledSet` bit L pulses, where L is the winning lane's index. A blocked load whose handled bit is already set is no event at all.
- R10: Each honoured mispredict adds one to `takenWrongCnt` if its predicted-taken bit is 1, and otherwise adds one to `notTakenWrongCnt`. Both counters update in the same cycle the record appears. Mispredicts suppressed by R3 are not counted.
- R11: A lane whose valid bit is 0 produces no event, whatever its status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| laneValid | input | LANES | Lane holds an instruction |
| laneTid | input | LANES*TID_W | Thread number per lane |
| laneSeq | input | LANES*SEQ_W | Sequence number per lane |
| lanePc | input | LANES*PC_W | PC per lane |
| laneNextPc | input | LANES*PC_W | Computed next PC per lane |
| laneMispred | input | LANES | Branch outcome differs from prediction |
| lanePredTaken | input | LANES | Branch was predicted taken |
| laneMemViol | input | LANES | Memory-ordering violation detected |
| laneLdBlocked | input | LANES | Load could not access memory |
| laneLdHandled | input | LANES | Blocked load already dealt with |
| sqValid | output | THREADS | Squash record valid per thread |
| sqSeq | output | THREADS*SEQ_W | Squash-from sequence number |
| sqMispredPc | output | THREADS*PC_W | PC of the mispredicted branch |
| sqNextPc | output | THREADS*PC_W | Restart PC |
| sqMispredict | output | THREADS | Record comes from a branch mispredict |
| sqTaken | output | THREADS | Corrected branch direction is taken |
| sqIncludeSelf | output | THREADS | Triggering instruction is squashed too |
| ldHandledSet | output | LANES | Mark the blocked load in this lane handled |
| takenWrongCnt | output | CNT_W | Honoured mispredicts predicted taken |
| notTakenWrongCnt | output | CNT_W | Honoured mispredicts predicted not taken |

## Verification
The bench targets groups where one lane sets several cause bits at once. A design that gets the priority wrong emits the wrong restart PC or the wrong include flag. It places a younger mispredict behind an older violation of the same thread: a design without the per-thread first-wins rule would overwrite the record or bump a counter. It checks a blocked load with the handled bit already set, and invalid lanes carrying cause bits, where a loose event decode would raise a spurious squash. Back-to-back groups on one thread and two threads in the same group expose a selection flag that fails to clear between groups or is shared across threads.

// File: rtl/sqarb_pkg.sv
package sqarb_pkg;

  // Strobes from the selection control to the record datapath, one per thread.
  typedef struct packed {
    logic fire;     // an event was honoured for this thread
    logic branch;   // cause: branch mispredict
    logic memOrd;   // cause: memory ordering violation
    logic ldBlk;    // cause: blocked load not yet handled
  } sqStrobeT;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_BRANCH = 2'd1,
    CAUSE_MEMORD = 2'd2,
    CAUSE_LDBLK  = 2'd3
  } causeT;

endpackage

// File: rtl/squash_ctrl.sv
module squash_ctrl
  import sqarb_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int THREADS = 2,
  parameter int TID_W   = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LANES-1:0]           laneValid,
  input  logic [LANES*TID_W-1:0]     laneTid,
  input  logic [LANES-1:0]           laneMispred,
  input  logic [LANES-1:0]           laneMemViol,
  input  logic [LANES-1:0]           laneLdBlocked,
  input  logic [LANES-1:0]           laneLdHandled,
  output sqStrobeT [THREADS-1:0]     strobe,
  output logic [THREADS*LANES-1:0]   laneSel
);

  causeT laneCause [LANES];
  logic [LANES-1:0] laneEvt;

  // Per-lane cause decode with fixed priority (R5) and valid gating (R11).
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      if (!laneValid[l])                             laneCause[l] = CAUSE_NONE;
      else if (laneMispred[l])                       laneCause[l] = CAUSE_BRANCH;
      else if (laneMemViol[l])                       laneCause[l] = CAUSE_MEMORD;
      else if (laneLdBlocked[l] && !laneLdHandled[l]) laneCause[l] = CAUSE_LDBLK;
      else                                           laneCause[l] = CAUSE_NONE;
    end
    assign laneEvt[l] = (laneCause[l] != CAUSE_NONE);
  end

  // Per-thread oldest-first selection; redirTaken starts clear each group (R3, R4).
  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic redirTaken;
    logic [LANES-1:0] pick;
    sqStrobeT st;

    always_comb begin
      redirTaken = 1'b0;
      pick       = '0;
      st         = '0;
      for (int l = 0; l < LANES; l++) begin
        if (!redirTaken && laneEvt[l] &&
            (laneTid[l*TID_W +: TID_W] == TID_W'(t))) begin
          redirTaken = 1'b1;
          pick[l]    = 1'b1;
          st.fire    = 1'b1;
          st.branch  = (laneCause[l] == CAUSE_BRANCH);
          st.memOrd  = (laneCause[l] == CAUSE_MEMORD);
          st.ldBlk   = (laneCause[l] == CAUSE_LDBLK);
        end
      end
    end

    assign strobe[t]                     = st;
    assign laneSel[t*LANES +: LANES]     = pick;

    // R3: at most one lane chosen per thread per group
    assert_one_winner_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(laneSel[t*LANES +: LANES]));

    // R5: a fired strobe names exactly one cause
    assert_single_cause_R5: assert property (@(posedge clk) disable iff (rst)
      strobe[t].fire |-> $onehot({strobe[t].branch, strobe[t].memOrd, strobe[t].ldBlk}));

    // R11: a chosen lane is always a valid one
    assert_valid_lane_R11: assert property (@(posedge clk) disable iff (rst)
      ((laneSel[t*LANES +: LANES] & ~laneValid) == '0));
  end

endmodule

// File: rtl/squash_dp.sv
module squash_dp
  import sqarb_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int THREADS    = 2,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int CNT_W      = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  sqStrobeT [THREADS-1:0]     strobe,
  input  logic [THREADS*LANES-1:0]   laneSel,
  input  logic [LANES*SEQ_W-1:0]     laneSeq,
  input  logic [LANES*PC_W-1:0]      lanePc,
  input  logic [LANES*PC_W-1:0]      laneNextPc,
  input  logic [LANES-1:0]           lanePredTaken,
  output logic [THREADS-1:0]         sqValid,
  output logic [THREADS*SEQ_W-1:0]   sqSeq,
  output logic [THREADS*PC_W-1:0]    sqMispredPc,
  output logic [THREADS*PC_W-1:0]    sqNextPc,
  output logic [THREADS-1:0]         sqMispredict,
  output logic [THREADS-1:0]         sqTaken,
  output logic [THREADS-1:0]         sqIncludeSelf,
  output logic [LANES-1:0]           ldHandledSet,
  output logic [CNT_W-1:0]           takenWrongCnt,
  output logic [CNT_W-1:0]           notTakenWrongCnt
);

  localparam int INC_W = $clog2(THREADS + 1);
  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  logic [THREADS-1:0] branchPredTaken;
  logic [THREADS-1:0] branchPredNot;

  for (genvar t = 0; t < THREADS; t++) begin : g_rec
    logic [SEQ_W-1:0] selSeq;
    logic [PC_W-1:0]  selPc, selNext;
    logic             selPt;
    logic             validQ, mispQ, takenQ, inclQ;
    logic [SEQ_W-1:0] seqQ;
    logic [PC_W-1:0]  mpPcQ, nextQ;

    // AND-OR mux driven by the one-hot lane select
    always_comb begin
      selSeq  = '0;
      selPc   = '0;
      selNext = '0;
      selPt   = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        if (laneSel[t*LANES + l]) begin
          selSeq  = selSeq  | laneSeq[l*SEQ_W +: SEQ_W];
          selPc   = selPc   | lanePc[l*PC_W +: PC_W];
          selNext = selNext | laneNextPc[l*PC_W +: PC_W];
          selPt   = selPt   | lanePredTaken[l];
        end
      end
    end

    assign branchPredTaken[t] = strobe[t].fire && strobe[t].branch && selPt;
    assign branchPredNot[t]   = strobe[t].fire && strobe[t].branch && !selPt;

    always_ff @(posedge clk) begin
      if (rst) begin
        validQ <= 1'b0;
        mispQ  <= 1'b0;
        takenQ <= 1'b0;
        inclQ  <= 1'b0;
        seqQ   <= '0;
        mpPcQ  <= '0;
        nextQ  <= '0;
      end else begin
        validQ <= strobe[t].fire;
        if (strobe[t].fire) begin
          seqQ  <= selSeq;
          mispQ <= strobe[t].branch;
          inclQ <= strobe[t].ldBlk;
          if (strobe[t].branch) begin
            mpPcQ  <= selPc;
            nextQ  <= selNext;
            takenQ <= (selNext != (selPc + STEP));
          end else if (strobe[t].memOrd) begin
            mpPcQ  <= '0;
            nextQ  <= selNext;
            takenQ <= 1'b0;
          end else begin
            mpPcQ  <= '0;
            nextQ  <= selPc;
            takenQ <= 1'b0;
          end
        end
      end
    end

    assign sqValid[t]                  = validQ;
    assign sqSeq[t*SEQ_W +: SEQ_W]     = seqQ;
    assign sqMispredPc[t*PC_W +: PC_W] = mpPcQ;
    assign sqNextPc[t*PC_W +: PC_W]    = nextQ;
    assign sqMispredict[t]             = mispQ;
    assign sqTaken[t]                  = takenQ;
    assign sqIncludeSelf[t]            = inclQ;

    // R2: a record only follows a group that fired for this thread
    assert_record_follows_R2: assert property (@(posedge clk) disable iff (rst)
      sqValid[t] |-> $past(strobe[t].fire));

    // R9: self-including squash never claims to be a mispredict
    assert_incl_not_branch_R9: assert property (@(posedge clk) disable iff (rst)
      (sqValid[t] && sqIncludeSelf[t]) |-> (!sqMispredict[t] && !sqTaken[t]));

    // R7: taken flag only accompanies a mispredict
    assert_taken_branch_R7: assert property (@(posedge clk) disable iff (rst)
      (sqValid[t] && sqTaken[t]) |-> sqMispredict[t]);
  end

  // Handled strobe back to the load queue (R9)
  logic [LANES-1:0] handledNext;
  always_comb begin
    handledNext = '0;
    for (int t = 0; t < THREADS; t++) begin
      if (strobe[t].fire && strobe[t].ldBlk)
        handledNext = handledNext | laneSel[t*LANES +: LANES];
    end
  end

  // Mispredict counters (R10)
  logic [INC_W-1:0] incTaken, incNot;
  always_comb begin
    incTaken = '0;
    incNot   = '0;
    for (int t = 0; t < THREADS; t++) begin
      incTaken = incTaken + INC_W'(branchPredTaken[t]);
      incNot   = incNot   + INC_W'(branchPredNot[t]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ldHandledSet     <= '0;
      takenWrongCnt    <= '0;
      notTakenWrongCnt <= '0;
    end else begin
      ldHandledSet     <= handledNext;
      takenWrongCnt    <= takenWrongCnt + CNT_W'(incTaken);
      notTakenWrongCnt <= notTakenWrongCnt + CNT_W'(incNot);
    end
  end

  // R10: counters move only together with a mispredict record
  assert_cnt_taken_R10: assert property (@(posedge clk) disable iff (rst)
    (takenWrongCnt != $past(takenWrongCnt)) |-> |(sqValid & sqMispredict));

  assert_cnt_not_taken_R10: assert property (@(posedge clk) disable iff (rst)
    (notTakenWrongCnt != $past(notTakenWrongCnt)) |-> |(sqValid & sqMispredict));

  // R9: a handled strobe comes with a self-including record
  assert_handled_pair_R9: assert property (@(posedge clk) disable iff (rst)
    (|ldHandledSet) |-> |(sqValid & sqIncludeSelf));

  assert_handled_count_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(ldHandledSet) <= $countones(sqValid & sqIncludeSelf));

endmodule

// File: rtl/exec_squash_arbiter.sv
module exec_squash_arbiter
  import sqarb_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int THREADS    = 2,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int CNT_W      = 16,
  localparam int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANES-1:0]         laneValid,
  input  logic [LANES*TID_W-1:0]   laneTid,
  input  logic [LANES*SEQ_W-1:0]   laneSeq,
  input  logic [LANES*PC_W-1:0]    lanePc,
  input  logic [LANES*PC_W-1:0]    laneNextPc,
  input  logic [LANES-1:0]         laneMispred,
  input  logic [LANES-1:0]         lanePredTaken,
  input  logic [LANES-1:0]         laneMemViol,
  input  logic [LANES-1:0]         laneLdBlocked,
  input  logic [LANES-1:0]         laneLdHandled,
  output logic [THREADS-1:0]       sqValid,
  output logic [THREADS*SEQ_W-1:0] sqSeq,
  output logic [THREADS*PC_W-1:0]  sqMispredPc,
  output logic [THREADS*PC_W-1:0]  sqNextPc,
  output logic [THREADS-1:0]       sqMispredict,
  output logic [THREADS-1:0]       sqTaken,
  output logic [THREADS-1:0]       sqIncludeSelf,
  output logic [LANES-1:0]         ldHandledSet,
  output logic [CNT_W-1:0]         takenWrongCnt,
  output logic [CNT_W-1:0]         notTakenWrongCnt
);

  sqStrobeT [THREADS-1:0]     strobe;
  logic [THREADS*LANES-1:0]   laneSel;

  squash_ctrl #(
    .LANES(LANES), .THREADS(THREADS), .TID_W(TID_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .laneValid(laneValid), .laneTid(laneTid),
    .laneMispred(laneMispred), .laneMemViol(laneMemViol),
    .laneLdBlocked(laneLdBlocked), .laneLdHandled(laneLdHandled),
    .strobe(strobe), .laneSel(laneSel)
  );

  squash_dp #(
    .LANES(LANES), .THREADS(THREADS), .SEQ_W(SEQ_W), .PC_W(PC_W),
    .INST_BYTES(INST_BYTES), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst(rst),
    .strobe(strobe), .laneSel(laneSel),
    .laneSeq(laneSeq), .lanePc(lanePc), .laneNextPc(laneNextPc),
    .lanePredTaken(lanePredTaken),
    .sqValid(sqValid), .sqSeq(sqSeq), .sqMispredPc(sqMispredPc),
    .sqNextPc(sqNextPc), .sqMispredict(sqMispredict), .sqTaken(sqTaken),
    .sqIncludeSelf(sqIncludeSelf), .ldHandledSet(ldHandledSet),
    .takenWrongCnt(takenWrongCnt), .notTakenWrongCnt(notTakenWrongCnt)
  );

endmodule

// File: tb/sim_exec_squash_arbiter.sv
module sim_exec_squash_arbiter;

  localparam int LANES = 4, THREADS = 2, SEQ_W = 16, PC_W = 32, CNT_W = 16, TID_W = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES-1:0]         laneValid, laneMispred, lanePredTaken, laneMemViol, laneLdBlocked, laneLdHandled;
  logic [LANES*TID_W-1:0]   laneTid;
  logic [LANES*SEQ_W-1:0]   laneSeq;
  logic [LANES*PC_W-1:0]    lanePc, laneNextPc;
  logic [THREADS-1:0]       sqValid, sqMispredict, sqTaken, sqIncludeSelf;
  logic [THREADS*SEQ_W-1:0] sqSeq;
  logic [THREADS*PC_W-1:0]  sqMispredPc, sqNextPc;
  logic [LANES-1:0]         ldHandledSet;
  logic [CNT_W-1:0]         takenWrongCnt, notTakenWrongCnt;

  int errors = 0, checks = 0, expTW = 0, expNTW = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  exec_squash_arbiter u0 (
    .clk(clk), .rst(rst), .laneValid(laneValid), .laneTid(laneTid), .laneSeq(laneSeq),
    .lanePc(lanePc), .laneNextPc(laneNextPc), .laneMispred(laneMispred),
    .lanePredTaken(lanePredTaken), .laneMemViol(laneMemViol), .laneLdBlocked(laneLdBlocked),
    .laneLdHandled(laneLdHandled), .sqValid(sqValid), .sqSeq(sqSeq), .sqMispredPc(sqMispredPc),
    .sqNextPc(sqNextPc), .sqMispredict(sqMispredict), .sqTaken(sqTaken),
    .sqIncludeSelf(sqIncludeSelf), .ldHandledSet(ldHandledSet),
    .takenWrongCnt(takenWrongCnt), .notTakenWrongCnt(notTakenWrongCnt)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearLanes();
    laneValid = '0; laneMispred = '0; lanePredTaken = '0; laneMemViol = '0;
    laneLdBlocked = '0; laneLdHandled = '0; laneTid = '0; laneSeq = '0;
    lanePc = '0; laneNextPc = '0;
  endtask

  task automatic setLane(int l, int tid, int seq, logic [31:0] pc, logic [31:0] npc,
                         bit mp, bit pt, bit mv, bit lb, bit lh);
    laneValid[l] = 1'b1;
    laneTid[l*TID_W +: TID_W] = TID_W'(tid);
    laneSeq[l*SEQ_W +: SEQ_W] = SEQ_W'(seq);
    lanePc[l*PC_W +: PC_W] = pc;
    laneNextPc[l*PC_W +: PC_W] = npc;
    laneMispred[l] = mp; lanePredTaken[l] = pt; laneMemViol[l] = mv;
    laneLdBlocked[l] = lb; laneLdHandled[l] = lh;
  endtask

  task automatic checkRec(string req, int t, int seq, logic [31:0] mpPc, logic [31:0] npc,
                          bit mp, bit tk, bit inc);
    chk(req, $sformatf("valid t%0d", t), sqValid[t], 1);
    chk(req, $sformatf("seq t%0d", t), sqSeq[t*SEQ_W +: SEQ_W], seq);
    chk(req, $sformatf("mispredPc t%0d", t), sqMispredPc[t*PC_W +: PC_W], mpPc);
    chk(req, $sformatf("nextPc t%0d", t), sqNextPc[t*PC_W +: PC_W], npc);
    chk(req, $sformatf("mispredict t%0d", t), sqMispredict[t], mp);
    chk(req, $sformatf("taken t%0d", t), sqTaken[t], tk);
    chk(req, $sformatf("include t%0d", t), sqIncludeSelf[t], inc);
  endtask

  task automatic checkCounters(string req);
    chk(req, "takenWrongCnt", takenWrongCnt, expTW);
    chk(req, "notTakenWrongCnt", notTakenWrongCnt, expNTW);
  endtask

  // apply a group, then check the record one clock later
  task automatic stepGroup();
    @(negedge clk);
  endtask

  task automatic idleCheck(string req);
    clearLanes();
    @(negedge clk);
    chk(req, "sqValid after pulse", sqValid, 0);
    chk(req, "ldHandledSet after pulse", ldHandledSet, 0);
  endtask

  task automatic testReset();
    chk("R1", "sqValid in reset", sqValid, 0);
    chk("R1", "ldHandledSet in reset", ldHandledSet, 0);
    checkCounters("R1");
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1", "sqValid idle", sqValid, 0);
  endtask

  task automatic testBranchTaken();   // R6 R7 R10
    clearLanes();
    setLane(1, 0, 5, 32'h100, 32'h110, 1, 0, 0, 0, 0);
    stepGroup(); expNTW++;
    checkRec("R6", 0, 5, 32'h100, 32'h110, 1, 1, 0);
    chk("R4", "no record t1", sqValid[1], 0);
    checkCounters("R10");
    idleCheck("R2");
  endtask

  task automatic testBranchFall();    // R7 R10
    clearLanes();
    setLane(0, 1, 7, 32'h200, 32'h204, 1, 1, 0, 0, 0);
    stepGroup(); expTW++;
    checkRec("R7", 1, 7, 32'h200, 32'h204, 1, 0, 0);
    checkCounters("R10");
    idleCheck("R2");
  endtask

  task automatic testPriority();      // R5 R8
    clearLanes();
    setLane(2, 0, 9, 32'h300, 32'h340, 1, 0, 1, 1, 0);
    stepGroup(); expNTW++;
    checkRec("R5", 0, 9, 32'h300, 32'h340, 1, 1, 0);
    chk("R5", "no handled strobe", ldHandledSet, 0);
    clearLanes();
    setLane(0, 0, 11, 32'h400, 32'h480, 0, 0, 1, 1, 0);
    stepGroup();
    checkRec("R8", 0, 11, 0, 32'h480, 0, 0, 0);
    chk("R5", "memord beats load", ldHandledSet, 0);
    checkCounters("R10");
    idleCheck("R2");
  endtask

  task automatic testFirstWins();     // R3 R10
    clearLanes();
    setLane(0, 0, 20, 32'h500, 32'h520, 0, 0, 1, 0, 0);
    setLane(1, 0, 21, 32'h504, 32'h600, 1, 1, 0, 0, 0);
    setLane(3, 0, 23, 32'h50c, 32'h510, 0, 0, 0, 1, 0);
    stepGroup();
    checkRec("R3", 0, 20, 0, 32'h520, 0, 0, 0);
    chk("R3", "younger load not handled", ldHandledSet, 0);
    checkCounters("R10");
    idleCheck("R2");
  endtask

  task automatic testTwoThreads();    // R4 R9
    clearLanes();
    setLane(0, 1, 30, 32'h600, 32'h604, 0, 0, 0, 1, 0);
    setLane(1, 0, 31, 32'h700, 32'h704, 1, 0, 0, 0, 0);
    setLane(2, 1, 32, 32'h608, 32'h900, 1, 1, 0, 0, 0);
    stepGroup(); expNTW++;
    checkRec("R9", 1, 30, 0, 32'h600, 0, 0, 1);
    chk("R9", "handled lane strobe", ldHandledSet, 4'b0001);
    checkRec("R4", 0, 31, 32'h700, 32'h704, 1, 0, 0);
    checkCounters("R10");
    idleCheck("R2");
  endtask

  task automatic testIgnored();       // R9 R11
    clearLanes();
    setLane(2, 0, 40, 32'h800, 32'h804, 0, 0, 0, 1, 1);
    setLane(3, 1, 41, 32'h880, 32'h990, 1, 1, 1, 1, 0);
    laneValid[3] = 1'b0;
    stepGroup();
    chk("R9", "handled load no record", sqValid[0], 0);
    chk("R11", "invalid lane no record", sqValid[1], 0);
    chk("R9", "no handled strobe", ldHandledSet, 0);
    checkCounters("R11");
    idleCheck("R2");
  endtask

  task automatic testBackToBack();    // R3 R2
    clearLanes();
    setLane(0, 0, 50, 32'ha00, 32'ha40, 0, 0, 1, 0, 0);
    stepGroup();
    checkRec("R3", 0, 50, 0, 32'ha40, 0, 0, 0);
    clearLanes();
    setLane(1, 0, 51, 32'hb00, 32'hb80, 0, 0, 1, 0, 0);
    stepGroup();
    checkRec("R3", 0, 51, 0, 32'hb80, 0, 0, 0);
    idleCheck("R2");
  endtask

  initial begin
    clearLanes();
    @(negedge clk); @(negedge clk);
    testReset();
    testBranchTaken();
    testBranchFall();
    testPriority();
    testFirstWins();
    testTwoThreads();
    testIgnored();
    testBackToBack();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule